// File: doc/BRIEF.md
# Dual-Clock FIFO with Loadable Threshold Flags

This block is a first-in first-out buffer for 9-bit words. Its write side and read side each run on their own free-running clock. The two clocks may be one and the same net, or they may be unrelated. A write needs both write-enable inputs high, and a read needs both read-enable inputs high. Read data lands in an output register. That register drives the data pins through an output-enable control, which floats the pins when it is low.

Four flags report the fill level:
- Empty and almost-empty are computed on the read clock.
- Full and almost-full are computed on the write clock.

Each domain sees the other side's pointer through a Gray-coded two-stage synchronizer. The two threshold offsets live in registers. While the load input is high, a qualified write goes into these registers instead of the array.

Top module: `async_flag_fifo`

## Requirements
- R1: Words come out in the order they were written, with all 9 bits intact.
- R2: A word is stored only on a write-clock rising edge where both write enables are high. With just one of them high, nothing is stored and the flags do not change.
- R3: The output register loads the next word only on a read-clock rising edge where both read enables are high. Otherwise it holds its value.
- R4: A write attempted while full is dropped. The write pointer does not move and the stored contents are unchanged.
- R5: A read attempted while empty is dropped. The output register and the read pointer keep their values.
- R6: Once the pointers have settled, empty is high exactly when the level is 0, and full is high exactly when the level equals DEPTH.
- R7: Until the offsets are programmed, both offsets are 7. Almost-empty is high when the level is 7 or less, and almost-full is high when the level is at least DEPTH-7.
- R8: While load is high, qualified writes alternate between two targets, starting with the almost-empty offset and then the almost-full offset. Each offset takes the 9-bit word zero-extended. The array is left untouched.
- R9: With an almost-empty offset E and an almost-full offset F, almost-empty is high when the level is at most E. Almost-full is high when the level is at least DEPTH-F.
- R10: When the output enable is low, the data pins are high-impedance. Another driver can then own the bus.
- R11: An active-low asynchronous reset does all of the following:
  - clears both pointers;
  - clears the output register to 0;
  - sets empty and almost-empty high, and full and almost-full low;
  - restores both offsets to 7;
  - restarts the load sequence at the almost-empty offset.
- R12: When the read clock is asynchronous to the write clock, a stream written under flow control is read back complete and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wen1_i | input | 1 | Write enable, first term |
| wen2_i | input | 1 | Write enable, second term |
| ld_i | input | 1 | Steers qualified writes to the offset registers |
| wdata_i | input | 9 | Write data |
| ren1_i | input | 1 | Read enable, first term |
| ren2_i | input | 1 | Read enable, second term |
| oe_i | input | 1 | Output enable; low floats rdata_o |
| rdata_o | output | 9 | Registered read data, three-state |
| empty_o | output | 1 | Empty flag (read domain) |
| almost_empty_o | output | 1 | Level at or below the almost-empty offset (read domain) |
| full_o | output | 1 | Full flag (write domain) |
| almost_full_o | output | 1 | Level at or above DEPTH minus the almost-full offset (write domain) |

## Verification
The bench builds the block with DEPTH=16. At that size, every fill level from 0 to full and back can be visited one word at a time, and all four flags are checked at each level. This is done first with the default offsets and then with programmed offsets of 3 and 12. Because the depth is small, the over-full and under-empty attempts, and the rollover of the pointers' wrap bit, occur many times in a short run. The final phase switches the read clock to a 7 ns period against the 5 ns write clock, so that the Gray crossing is exercised with drifting phase.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  parameter int unsigned FIFO_DW     = 9;
  parameter int unsigned FIFO_DEF_OF = 7;
endpackage

// File: rtl/gray_sync.sv
// Registers a binary pointer as Gray in the source domain, double-flops it
// into the destination domain and converts back to binary.
module gray_sync #(
  parameter int unsigned W = 9
) (
  input  logic         src_clk_i,
  input  logic         dst_clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] src_gray, s1, s2;

  always_ff @(posedge src_clk_i or negedge rst_ni)
    if (!rst_ni) src_gray <= '0;
    else         src_gray <= bin_i ^ (bin_i >> 1);

  always_ff @(posedge dst_clk_i or negedge rst_ni)
    if (!rst_ni) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= src_gray;
      s2 <= s1;
    end

  always_comb begin
    bin_o[W-1] = s2[W-1];
    for (int i = W - 2; i >= 0; i--) bin_o[i] = bin_o[i+1] ^ s2[i];
  end
endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl #(
  parameter int unsigned AW      = 8,
  parameter int unsigned DW      = 9,
  parameter int unsigned DEF_OFS = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          ld_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW:0]   rptr_i,
  output logic [AW:0]   wptr_o,
  output logic          mem_we_o,
  output logic [DW-1:0] ae_ofs_o,
  output logic          full_o,
  output logic          almost_full_o
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned CW    = ((AW + 1 > DW) ? AW + 1 : DW) + 1;

  logic [AW:0]   level;
  logic [DW-1:0] af_ofs;
  logic          ld_sel;  // 0: almost-empty offset next, 1: almost-full

  assign level         = wptr_o - rptr_i;
  assign full_o        = (level == (AW+1)'(DEPTH));
  assign almost_full_o = (CW'(level) + CW'(af_ofs)) >= CW'(DEPTH);
  assign mem_we_o      = we_i && !ld_i && !full_o;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wptr_o   <= '0;
      ae_ofs_o <= DW'(DEF_OFS);
      af_ofs   <= DW'(DEF_OFS);
      ld_sel   <= 1'b0;
    end else if (we_i && ld_i) begin
      if (ld_sel) af_ofs   <= wdata_i;
      else        ae_ofs_o <= wdata_i;
      ld_sel <= ~ld_sel;
    end else if (mem_we_o) begin
      wptr_o <= wptr_o + 1'b1;
    end
endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [AW:0]   wptr_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [DW-1:0] ae_ofs_i,
  output logic [AW:0]   rptr_o,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          almost_empty_o
);
  localparam int unsigned CW = ((AW + 1 > DW) ? AW + 1 : DW) + 1;

  logic [AW:0] level;

  assign level          = wptr_i - rptr_o;
  assign empty_o        = (level == '0);
  // offset is quasi-static: only reloaded while the buffer is idle
  assign almost_empty_o = CW'(level) <= CW'(ae_ofs_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rptr_o  <= '0;
      rdata_o <= '0;
    end else if (re_i && !empty_o) begin
      rptr_o  <= rptr_o + 1'b1;
      rdata_o <= mem_rdata_i;
    end
endmodule

// File: rtl/async_flag_fifo.sv
module async_flag_fifo #(
  parameter int unsigned DEPTH = 256
) (
  input  logic                        wclk_i,
  input  logic                        rclk_i,
  input  logic                        rst_ni,
  input  logic                        wen1_i,
  input  logic                        wen2_i,
  input  logic                        ld_i,
  input  logic [fifo_pkg::FIFO_DW-1:0] wdata_i,
  input  logic                        ren1_i,
  input  logic                        ren2_i,
  input  logic                        oe_i,
  output wire  [fifo_pkg::FIFO_DW-1:0] rdata_o,
  output logic                        empty_o,
  output logic                        almost_empty_o,
  output logic                        full_o,
  output logic                        almost_full_o
);
  localparam int unsigned DW = fifo_pkg::FIFO_DW;
  localparam int unsigned AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wr_ptr, rd_ptr, wptr_sync, rptr_sync;
  logic [DW-1:0] ae_ofs, rd_q, mem_rdata;
  logic          mem_we;

  fifo_wr_ctl #(.AW(AW), .DW(DW), .DEF_OFS(fifo_pkg::FIFO_DEF_OF)) u_wr (
    .clk_i        (wclk_i),
    .rst_ni       (rst_ni),
    .we_i         (wen1_i & wen2_i),
    .ld_i         (ld_i),
    .wdata_i      (wdata_i),
    .rptr_i       (rptr_sync),
    .wptr_o       (wr_ptr),
    .mem_we_o     (mem_we),
    .ae_ofs_o     (ae_ofs),
    .full_o       (full_o),
    .almost_full_o(almost_full_o)
  );

  fifo_rd_ctl #(.AW(AW), .DW(DW)) u_rd (
    .clk_i         (rclk_i),
    .rst_ni        (rst_ni),
    .re_i          (ren1_i & ren2_i),
    .wptr_i        (wptr_sync),
    .mem_rdata_i   (mem_rdata),
    .ae_ofs_i      (ae_ofs),
    .rptr_o        (rd_ptr),
    .rdata_o       (rd_q),
    .empty_o       (empty_o),
    .almost_empty_o(almost_empty_o)
  );

  gray_sync #(.W(AW + 1)) u_w2r (
    .src_clk_i(wclk_i), .dst_clk_i(rclk_i), .rst_ni(rst_ni),
    .bin_i(wr_ptr), .bin_o(wptr_sync)
  );

  gray_sync #(.W(AW + 1)) u_r2w (
    .src_clk_i(rclk_i), .dst_clk_i(wclk_i), .rst_ni(rst_ni),
    .bin_i(rd_ptr), .bin_o(rptr_sync)
  );

  always_ff @(posedge wclk_i)
    if (mem_we) mem[wr_ptr[AW-1:0]] <= wdata_i;

  assign mem_rdata = mem[rd_ptr[AW-1:0]];
  assign rdata_o   = oe_i ? rd_q : {DW{1'bz}};
endmodule

// File: rtl/async_flag_fifo_chk.sv
module async_flag_fifo_chk #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 9
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          wen1_i,
  input logic          wen2_i,
  input logic          ld_i,
  input logic          ren1_i,
  input logic          ren2_i,
  input logic          full_o,
  input logic          almost_full_o,
  input logic          empty_o,
  input logic          almost_empty_o,
  input logic [AW:0]   wr_ptr,
  input logic [DW-1:0] rd_q
);
  p_single_wen_r2: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !(wen1_i && wen2_i) |=> $stable(wr_ptr));

  p_rd_hold_r3: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !(ren1_i && ren2_i) |=> $stable(rd_q));

  p_no_overflow_r4: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (full_o && wen1_i && wen2_i && !ld_i) |=> $stable(wr_ptr));

  p_no_underflow_r5: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (empty_o && ren1_i && ren2_i) |=> $stable(rd_q));

  p_empty_in_ae_r7: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    empty_o |-> almost_empty_o);

  p_full_in_af_r9: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_o |-> almost_full_o);

  p_load_no_store_r8: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (ld_i && wen1_i && wen2_i) |=> $stable(wr_ptr));
endmodule

bind async_flag_fifo async_flag_fifo_chk #(.AW($clog2(DEPTH)), .DW(fifo_pkg::FIFO_DW)) u_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni),
  .wen1_i(wen1_i), .wen2_i(wen2_i), .ld_i(ld_i),
  .ren1_i(ren1_i), .ren2_i(ren2_i),
  .full_o(full_o), .almost_full_o(almost_full_o),
  .empty_o(empty_o), .almost_empty_o(almost_empty_o),
  .wr_ptr(wr_ptr), .rd_q(rd_q)
);

// File: tb/tb_async_flag_fifo.sv
module tb_async_flag_fifo;
  localparam int DEPTH = 16;

  logic clk_a = 1'b0, clk_b = 1'b0, async_mode = 1'b0;
  always #2.5 clk_a = ~clk_a;
  always #3.5 clk_b = ~clk_b;
  wire rclk = async_mode ? clk_b : clk_a;

  logic rst_ni = 1'b0;
  logic wen1 = 0, wen2 = 0, ld = 0, ren1 = 0, ren2 = 0, oe = 1;
  logic [8:0] wdata = '0;
  logic empty, aempty, full, afull;
  wire  [8:0] q_bus;
  logic tb_drv = 1'b0;
  logic [8:0] tb_val = '0;
  assign q_bus = tb_drv ? tb_val : 9'bz;

  async_flag_fifo #(.DEPTH(DEPTH)) dut (
    .wclk_i(clk_a), .rclk_i(rclk), .rst_ni(rst_ni),
    .wen1_i(wen1), .wen2_i(wen2), .ld_i(ld), .wdata_i(wdata),
    .ren1_i(ren1), .ren2_i(ren2), .oe_i(oe), .rdata_o(q_bus),
    .empty_o(empty), .almost_empty_o(aempty), .full_o(full), .almost_full_o(afull)
  );

  int checks = 0, fails = 0, wr_idx = 0, rd_idx = 0, lvl = 0;
  bit done = 1'b0;

  function automatic int dval(int i);
    return (i * 37 + 5) % 512;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(int d);
    wen1 = 1; wen2 = 1; wdata = 9'(d);
    @(negedge clk_a);
    wen1 = 0; wen2 = 0;
  endtask

  task automatic pop();
    ren1 = 1; ren2 = 1;
    @(negedge rclk);
    ren1 = 0; ren2 = 0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk_a);
  endtask

  task automatic flags(int aeo, int afo);
    chk("R6 empty", int'(empty), int'(lvl == 0));
    chk("R6 full", int'(full), int'(lvl == DEPTH));
    chk(aeo == 7 ? "R7 almost_empty" : "R9 almost_empty", int'(aempty), int'(lvl <= aeo));
    chk(afo == 7 ? "R7 almost_full" : "R9 almost_full", int'(afull), int'(lvl >= DEPTH - afo));
  endtask

  task automatic do_reset();
    rst_ni = 0;
    repeat (2) @(negedge clk_a);
    rst_ni = 1;
    lvl = 0; rd_idx = wr_idx;
    @(negedge clk_a);
  endtask

  task automatic fill_drain(int aeo, int afo);
    for (int k = 0; k < DEPTH; k++) begin
      push(dval(wr_idx)); wr_idx++; lvl++;
      settle(); flags(aeo, afo);
    end
    push(9'h1AA);  // R4: dropped while full
    settle();
    chk("R4 full held", int'(full), 1);
    for (int k = 0; k < DEPTH; k++) begin
      pop(); lvl--;
      chk("R1 data", int'(q_bus), dval(rd_idx)); rd_idx++;
      if (k == 0) begin
        ren1 = 1; @(negedge clk_a); ren1 = 0;
        ren2 = 1; @(negedge clk_a); ren2 = 0;
        chk("R3 single ren holds data", int'(q_bus), dval(rd_idx - 1));
      end
      settle(); flags(aeo, afo);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL R12 watchdog actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_a);
    // R11: reset state
    chk("R11 empty", int'(empty), 1);
    chk("R11 almost_empty", int'(aempty), 1);
    chk("R11 full", int'(full), 0);
    chk("R11 almost_full", int'(afull), 0);
    rst_ni = 1;
    @(negedge clk_a);
    chk("R11 rdata zero", int'(q_bus), 0);

    // R2: a single write enable stores nothing
    wen1 = 1; wdata = 9'h055; @(negedge clk_a); wen1 = 0;
    wen2 = 1; wdata = 9'h0AA; @(negedge clk_a); wen2 = 0;
    settle();
    chk("R2 empty after single wen", int'(empty), 1);
    chk("R2 almost_empty after single wen", int'(aempty), 1);

    // R5: read while empty dropped
    pop(); settle();
    chk("R5 rdata held", int'(q_bus), 0);
    chk("R5 still empty", int'(empty), 1);

    fill_drain(7, 7);

    // R10: output floats, another driver owns the bus
    push(dval(wr_idx)); wr_idx++; lvl++; settle(); pop(); lvl--; rd_idx++;
    chk("R10 driven", int'(q_bus), dval(rd_idx - 1));
    oe = 0; tb_val = 9'h13C; tb_drv = 1; #1;
    chk("R10 hi-z bus", int'(q_bus), 9'h13C);
    tb_drv = 0; oe = 1; #1;
    chk("R10 re-driven", int'(q_bus), dval(rd_idx - 1));
    @(negedge clk_a);

    // R8: load almost-empty offset then almost-full offset
    ld = 1; push(3); push(12); ld = 0; settle();
    chk("R8 array untouched", int'(empty), 1);
    fill_drain(3, 12);

    // R11: reset restores default offsets and restarts load sequence
    ld = 1; push(2); ld = 0;
    do_reset();
    fill_drain(7, 7);
    ld = 1; push(5); ld = 0; settle();  // must go to almost-empty offset
    fill_drain(5, 7);

    // R12: asynchronous read clock
    rst_ni = 0; async_mode = 1;
    repeat (4) @(negedge clk_a);
    rst_ni = 1; lvl = 0; rd_idx = wr_idx;
    @(negedge clk_a);
    fork
      begin
        for (int i = 0; i < 120; i++) begin
          while (full) @(negedge clk_a);
          push(dval(wr_idx)); wr_idx++;
        end
      end
      begin
        @(negedge rclk);
        for (int j = 0; j < 120; j++) begin
          while (empty) @(negedge rclk);
          pop();
          chk("R12 async order", int'(q_bus), dval(rd_idx)); rd_idx++;
        end
      end
    join
    repeat (8) @(negedge clk_a);
    chk("R12 drained empty", int'(empty), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule